// File: doc/BRIEF.md
# Multi-Mode Preset Counter

This block is an up/down counter driven by single-cycle count strobes and a direction input. A 2-bit mode input selects one of four limiting behaviours, and each of them refers to a preset register. In free-running mode the counter wraps and reports overflow and underflow. In one-shot mode it stops itself after the first overflow or underflow. In clamp mode it stops at the preset when counting up and at zero when counting down. In divide-by-n mode it rolls over between zero and the preset.

Beside the counter sit the preset register and an output latch that captures a snapshot of the count. A synchronous index input can be assigned to one of three actions by a 2-bit selector: load the preset, clear the count, or latch the count. The host can issue the same three actions as direct commands. A disable input stops all counting.

The block sends registered one-cycle event pulses to a separate flag block: carry, borrow, compare (with the direction of the step that caused it) and modulo rollover. The counter width is a parameter and defaults to 32 bits.

Top module: `mmp_counter`

## Requirements
- R1: After reset, `cnt_q`, `ol_q` and `pr_q` are zero, every event pulse is low, and counting is enabled.
- R2: In mode 00 (free-running), a strobe with `cnt_up`=1 adds one and wraps from all-ones to zero, raising `carry_p`. A strobe with `cnt_up`=0 subtracts one and wraps from zero to all-ones, raising `borrow_p`. Each pulse lasts one cycle and appears together with the new count.
- R3: While `cnt_dis`=1, count strobes leave `cnt_q` unchanged and raise no event pulse.
- R4: In mode 01 (one-shot), the step that raises `carry_p` or `borrow_p` still wraps the counter. After it, strobes are ignored until a clear or a load, from the host or from the index, re-enables counting.
- R5: In mode 10 (clamp), an up strobe with `cnt_q` equal to the preset leaves the count unchanged, and a down strobe at zero leaves it unchanged. A strobe in the opposite direction moves the count again.
- R6: In mode 11 (divide-by-n), an up strobe at `cnt_q`==preset gives zero and a down strobe at zero gives the preset. Each such rollover raises `roll_p` for one cycle.
- R7: `cmp_p` is high for one cycle when a count step changes `cnt_q` to a value equal to the preset held before that edge. In that cycle `cmp_dir` gives the direction of the step (1 up, 0 down).
- R8: With `idx_in`=1 at an edge, `idx_sel` 00 does nothing, 01 copies the preset into the counter, 10 clears the counter, and 11 copies the counter into `ol_q`.
- R9: `cmd_clear` zeroes the counter, and `cmd_load` copies the preset held before the edge into it. Clear takes priority over load. `cmd_latch` copies the count from before the edge into `ol_q`, and a count step may happen in the same cycle.
- R10: When any host command is high, the index action of that cycle is ignored. A load or a clear from either source overrides a count strobe in the same cycle.
- R11: `pr_wr`=1 stores `pr_wdata` into the preset, and `pr_q` shows it in the next cycle.
- R12: `carry_p` and `borrow_p` occur only in modes 00 and 01. `roll_p` occurs only in mode 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Limiting mode: 00 free, 01 one-shot, 10 clamp, 11 divide-by-n |
| idx_sel | input | 2 | Index action: 00 none, 01 load, 10 clear, 11 latch |
| cnt_dis | input | 1 | 1 blocks counting |
| cnt_stb | input | 1 | Count strobe, one step per cycle high |
| cnt_up | input | 1 | Step direction, 1 = up |
| idx_in | input | 1 | Index event, active high |
| cmd_load | input | 1 | Host: preset to counter |
| cmd_clear | input | 1 | Host: clear counter |
| cmd_latch | input | 1 | Host: counter to output latch |
| pr_wr | input | 1 | Preset write strobe |
| pr_wdata | input | W | Preset write data |
| cnt_q | output | W | Counter value |
| ol_q | output | W | Output latch |
| pr_q | output | W | Preset register |
| carry_p | output | 1 | Overflow pulse |
| borrow_p | output | 1 | Underflow pulse |
| cmp_p | output | 1 | Counter reached preset by counting |
| cmp_dir | output | 1 | Direction of the last applied step |
| roll_p | output | 1 | Divide-by-n rollover pulse |

## Verification
The most delicate overlap is a host command and an index action arriving in the same cycle, often together with a count strobe. The host command must win, and a load or clear must drop the step, while a latch must let it through. Directed cases put `cmd_latch` against an index clear, `cmd_load` against a strobe, and clear against load. A seeded random phase then raises commands, index events and strobes together at random. Every cycle is judged against a bench model built from the priority rules, with an 8-bit counter so that wraps, clamps and rollovers occur often.

// File: rtl/mmpc_pkg.sv
package mmpc_pkg;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'b00,
        MODE_ONESHOT = 2'b01,
        MODE_CLAMP   = 2'b10,
        MODE_DIVN    = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        IX_NONE  = 2'b00,
        IX_LOAD  = 2'b01,
        IX_CLEAR = 2'b10,
        IX_LATCH = 2'b11
    } ix_fn_e;

endpackage

// File: rtl/mmpc_action.sv
module mmpc_action
    import mmpc_pkg::*;
(
    input  logic       cmd_load,
    input  logic       cmd_clear,
    input  logic       cmd_latch,
    input  logic       idx_in,
    input  logic [1:0] idx_sel,
    output logic       do_load,
    output logic       do_clear,
    output logic       do_latch
);
    logic host_any;

    always_comb begin
        host_any = cmd_load | cmd_clear | cmd_latch;
        do_load  = 1'b0;
        do_clear = 1'b0;
        do_latch = 1'b0;
        if (host_any) begin
            // host wins; clear beats load
            do_clear = cmd_clear;
            do_load  = cmd_load & ~cmd_clear;
            do_latch = cmd_latch;
        end else if (idx_in) begin
            do_load  = (idx_sel == IX_LOAD);
            do_clear = (idx_sel == IX_CLEAR);
            do_latch = (idx_sel == IX_LATCH);
        end
    end
endmodule

// File: rtl/mmpc_step.sv
module mmpc_step
    import mmpc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] pre,
    input  logic         up,
    input  logic [1:0]   mode,
    output logic [W-1:0] nxt,
    output logic         carry,
    output logic         borrow,
    output logic         roll
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ZERO     = '0;

    logic at_top;
    logic at_zero;
    logic at_pre;

    always_comb begin
        at_top  = (cur == ALL_ONES);
        at_zero = (cur == ZERO);
        at_pre  = (cur == pre);
        nxt     = up ? cur + 1'b1 : cur - 1'b1;
        carry   = 1'b0;
        borrow  = 1'b0;
        roll    = 1'b0;
        case (mode)
            MODE_FREE, MODE_ONESHOT: begin
                carry  = up & at_top;
                borrow = ~up & at_zero;
            end
            MODE_CLAMP: begin
                if (up && at_pre)       nxt = cur;
                if (!up && at_zero)     nxt = cur;
            end
            default: begin
                if (up && at_pre) begin
                    nxt  = ZERO;
                    roll = 1'b1;
                end else if (!up && at_zero) begin
                    nxt  = pre;
                    roll = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/mmp_counter.sv
module mmp_counter
    import mmpc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [1:0]   idx_sel,
    input  logic         cnt_dis,
    input  logic         cnt_stb,
    input  logic         cnt_up,
    input  logic         idx_in,
    input  logic         cmd_load,
    input  logic         cmd_clear,
    input  logic         cmd_latch,
    input  logic         pr_wr,
    input  logic [W-1:0] pr_wdata,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] ol_q,
    output logic [W-1:0] pr_q,
    output logic         carry_p,
    output logic         borrow_p,
    output logic         cmp_p,
    output logic         cmp_dir,
    output logic         roll_p
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] ol;
        logic [W-1:0] pr;
        logic         run;
        logic         carry;
        logic         borrow;
        logic         cmp;
        logic         dir;
        logic         roll;
    } state_t;

    state_t s_d, s_q;

    logic         do_load, do_clear, do_latch;
    logic [W-1:0] step_nxt;
    logic         step_carry, step_borrow, step_roll;
    logic         accept;

    mmpc_action u_act (
        .cmd_load (cmd_load),
        .cmd_clear(cmd_clear),
        .cmd_latch(cmd_latch),
        .idx_in   (idx_in),
        .idx_sel  (idx_sel),
        .do_load  (do_load),
        .do_clear (do_clear),
        .do_latch (do_latch)
    );

    mmpc_step #(.W(W)) u_step (
        .cur   (s_q.cnt),
        .pre   (s_q.pr),
        .up    (cnt_up),
        .mode  (mode),
        .nxt   (step_nxt),
        .carry (step_carry),
        .borrow(step_borrow),
        .roll  (step_roll)
    );

    always_comb begin
        s_d        = s_q;
        s_d.carry  = 1'b0;
        s_d.borrow = 1'b0;
        s_d.cmp    = 1'b0;
        s_d.roll   = 1'b0;
        accept     = cnt_stb & ~cnt_dis & (s_q.run | (mode != MODE_ONESHOT));

        if (pr_wr)    s_d.pr = pr_wdata;
        if (do_latch) s_d.ol = s_q.cnt;

        if (do_clear) begin
            s_d.cnt = '0;
            s_d.run = 1'b1;
        end else if (do_load) begin
            s_d.cnt = s_q.pr;
            s_d.run = 1'b1;
        end else if (accept) begin
            s_d.cnt    = step_nxt;
            s_d.carry  = step_carry;
            s_d.borrow = step_borrow;
            s_d.roll   = step_roll;
            s_d.cmp    = (step_nxt != s_q.cnt) && (step_nxt == s_q.pr);
            s_d.dir    = cnt_up;
            if ((mode == MODE_ONESHOT) && (step_carry || step_borrow))
                s_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.run <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q    = s_q.cnt;
    assign ol_q     = s_q.ol;
    assign pr_q     = s_q.pr;
    assign carry_p  = s_q.carry;
    assign borrow_p = s_q.borrow;
    assign cmp_p    = s_q.cmp;
    assign cmp_dir  = s_q.dir;
    assign roll_p   = s_q.roll;
endmodule

// File: rtl/mmpc_chk.sv
module mmpc_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode,
    input logic [1:0]   idx_sel,
    input logic         cnt_dis,
    input logic         cnt_up,
    input logic         idx_in,
    input logic         cmd_load,
    input logic         cmd_clear,
    input logic         cmd_latch,
    input logic         pr_wr,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] pr_q,
    input logic         carry_p,
    input logic         borrow_p,
    input logic         cmp_p,
    input logic         roll_p
);
    logic no_wr_act;
    assign no_wr_act = !cmd_load && !cmd_clear &&
                       !(idx_in && (idx_sel == 2'b01 || idx_sel == 2'b10));

    // R3
    dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_dis && no_wr_act) |=> $stable(cnt_q));

    // R5
    clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && cnt_up && cnt_q == pr_q && no_wr_act) |=> $stable(cnt_q));

    // R9
    host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |=> (cnt_q == '0));

    // R8
    idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_in && idx_sel == 2'b10 && !cmd_load && !cmd_clear && !cmd_latch)
        |=> (cnt_q == '0));

    // R12
    carry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_p || borrow_p) |-> !$past(mode[1]));

    // R12
    roll_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        roll_p |-> ($past(mode) == 2'b11));

    // R2
    wrap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry_p && borrow_p));

    // R7
    cmp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_p && !$past(pr_wr)) |-> (cnt_q == pr_q));
endmodule

bind mmp_counter mmpc_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .idx_sel  (idx_sel),
    .cnt_dis  (cnt_dis),
    .cnt_up   (cnt_up),
    .idx_in   (idx_in),
    .cmd_load (cmd_load),
    .cmd_clear(cmd_clear),
    .cmd_latch(cmd_latch),
    .pr_wr    (pr_wr),
    .cnt_q    (cnt_q),
    .pr_q     (pr_q),
    .carry_p  (carry_p),
    .borrow_p (borrow_p),
    .cmp_p    (cmp_p),
    .roll_p   (roll_p)
);

// File: tb/sim_mmp_counter.sv
`timescale 1ns/1ps
module sim_mmp_counter;
    localparam int BW = 8;
    localparam logic [BW-1:0] MAXV = {BW{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]    d_mode = 2'b00, d_sel = 2'b00;
    logic          d_dis = 0, d_stb = 0, d_up = 1, d_idx = 0;
    logic          d_load = 0, d_clear = 0, d_latch = 0, d_prwr = 0;
    logic [BW-1:0] d_prdata = '0;

    logic [BW-1:0] cnt_q, ol_q, pr_q;
    logic          carry_p, borrow_p, cmp_p, cmp_dir, roll_p;

    mmp_counter #(.W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(d_mode), .idx_sel(d_sel),
        .cnt_dis(d_dis), .cnt_stb(d_stb), .cnt_up(d_up), .idx_in(d_idx),
        .cmd_load(d_load), .cmd_clear(d_clear), .cmd_latch(d_latch),
        .pr_wr(d_prwr), .pr_wdata(d_prdata),
        .cnt_q(cnt_q), .ol_q(ol_q), .pr_q(pr_q), .carry_p(carry_p),
        .borrow_p(borrow_p), .cmp_p(cmp_p), .cmp_dir(cmp_dir), .roll_p(roll_p)
    );

    int checks = 0;
    int fails  = 0;

    logic [BW-1:0] m_cnt, m_ol, m_pr;
    logic          m_run, m_carry, m_borrow, m_cmp, m_dir, m_roll;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    // expected next state, from the requirements
    task automatic model_step();
        logic ld, cl, la, acc;
        logic [BW-1:0] old_cnt, old_pr, n;
        ld = 0; cl = 0; la = 0;
        m_carry = 0; m_borrow = 0; m_cmp = 0; m_roll = 0;
        old_cnt = m_cnt; old_pr = m_pr;
        if (d_load || d_clear || d_latch) begin
            cl = d_clear; ld = d_load && !d_clear; la = d_latch;
        end else if (d_idx) begin
            ld = (d_sel == 2'b01); cl = (d_sel == 2'b10); la = (d_sel == 2'b11);
        end
        if (la) m_ol = old_cnt;
        if (d_prwr) m_pr = d_prdata;
        acc = d_stb && !d_dis && (m_run || d_mode != 2'b01);
        if (cl) begin
            m_cnt = '0; m_run = 1;
        end else if (ld) begin
            m_cnt = old_pr; m_run = 1;
        end else if (acc) begin
            if (d_mode[1] == 1'b0) begin
                if (d_up) begin n = old_cnt + 1; m_carry = (old_cnt == MAXV); end
                else      begin n = old_cnt - 1; m_borrow = (old_cnt == 0); end
                if (d_mode == 2'b01 && (m_carry || m_borrow)) m_run = 0;
            end else if (d_mode == 2'b10) begin
                if (d_up) n = (old_cnt == old_pr) ? old_cnt : old_cnt + 1;
                else      n = (old_cnt == 0) ? old_cnt : old_cnt - 1;
            end else begin
                if (d_up && old_cnt == old_pr)   begin n = 0; m_roll = 1; end
                else if (!d_up && old_cnt == 0)  begin n = old_pr; m_roll = 1; end
                else n = d_up ? old_cnt + 1 : old_cnt - 1;
            end
            m_cmp = (n != old_cnt) && (n == old_pr);
            m_dir = d_up;
            m_cnt = n;
        end
    endtask

    // apply current drive for one edge, then compare at the following negedge
    task automatic tick();
        model_step();
        @(negedge clk);
        chk(mode_tag(d_mode), cnt_q, m_cnt);
        chk("R8", ol_q, m_ol);
        chk("R11", pr_q, m_pr);
        chk("R2", {borrow_p, carry_p}, {m_borrow, m_carry});
        chk("R7", {cmp_p, cmp_dir}, {m_cmp, m_dir});
        chk("R6", roll_p, m_roll);
        d_stb = 0; d_idx = 0; d_load = 0; d_clear = 0; d_latch = 0; d_prwr = 0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin d_stb = 1; tick(); end
    endtask

    task automatic set_pr(input logic [BW-1:0] v);
        d_prwr = 1; d_prdata = v; tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        m_cnt = 0; m_ol = 0; m_pr = 0; m_run = 1;
        m_carry = 0; m_borrow = 0; m_cmp = 0; m_dir = 0; m_roll = 0;
        // R1 reset state
        chk("R1", {cnt_q, ol_q, pr_q}, '0);
        chk("R1", {carry_p, borrow_p, cmp_p, roll_p}, 4'b0);

        // R11 preset write, R9 load
        set_pr(8'hFE);
        chk("R11", pr_q, 8'hFE);
        d_load = 1; tick();
        chk("R9", cnt_q, 8'hFE);

        // R2 wrap up and down
        strobes(1);
        chk("R2", cnt_q, 8'hFF);
        strobes(1);
        chk("R2", {cnt_q, carry_p}, {8'h00, 1'b1});
        d_up = 0; strobes(1);
        chk("R2", {cnt_q, borrow_p}, {8'hFF, 1'b1});

        // R3 disabled
        d_dis = 1; strobes(3);
        chk("R3", cnt_q, 8'hFF);
        d_dis = 0;

        // R4 one-shot
        d_mode = 2'b01; d_up = 1; strobes(1);
        chk("R4", {cnt_q, carry_p}, {8'h00, 1'b1});
        strobes(2);
        chk("R4", cnt_q, 8'h00);
        d_clear = 1; tick();
        strobes(1);
        chk("R4", cnt_q, 8'h01);

        // R5 clamp
        d_mode = 2'b10; set_pr(8'h03);
        d_clear = 1; tick();
        strobes(5);
        chk("R5", cnt_q, 8'h03);
        chk("R12", {carry_p, borrow_p, roll_p}, 3'b0);
        d_up = 0; strobes(5);
        chk("R5", cnt_q, 8'h00);
        d_up = 1; strobes(1);
        chk("R5", cnt_q, 8'h01);

        // R6 divide-by-n, R7 compare up
        d_mode = 2'b11; set_pr(8'h02);
        d_clear = 1; tick();
        strobes(2);
        chk("R7", {cnt_q, cmp_p, cmp_dir}, {8'h02, 1'b1, 1'b1});
        strobes(1);
        chk("R6", {cnt_q, roll_p}, {8'h00, 1'b1});
        chk("R12", {carry_p, borrow_p}, 2'b0);
        d_up = 0; strobes(1);
        chk("R6", {cnt_q, roll_p}, {8'h02, 1'b1});
        strobes(1);
        chk("R6", {cnt_q, roll_p}, {8'h01, 1'b0});

        // R7 compare down in free mode
        d_mode = 2'b00; set_pr(8'h04);
        d_load = 1; tick();
        d_up = 1; strobes(1);
        d_up = 0; strobes(1);
        chk("R7", {cnt_q, cmp_p, cmp_dir}, {8'h04, 1'b1, 1'b0});

        // R8 index functions
        d_sel = 2'b00; d_idx = 1; tick();
        chk("R8", cnt_q, 8'h04);
        d_sel = 2'b10; d_idx = 1; tick();
        chk("R8", cnt_q, 8'h00);
        d_sel = 2'b01; d_idx = 1; tick();
        chk("R8", cnt_q, 8'h04);
        d_up = 1; strobes(1);
        d_sel = 2'b11; d_idx = 1; tick();
        chk("R8", {ol_q, cnt_q}, {8'h05, 8'h05});

        // R10 host beats index; load beats count
        strobes(1);
        d_sel = 2'b10; d_idx = 1; d_latch = 1; tick();
        chk("R10", {ol_q, cnt_q}, {8'h06, 8'h06});
        d_load = 1; d_stb = 1; tick();
        chk("R10", cnt_q, 8'h04);
        d_load = 1; d_clear = 1; tick();
        chk("R9", cnt_q, 8'h00);
        d_latch = 1; d_stb = 1; tick();
        chk("R9", {ol_q, cnt_q}, {8'h00, 8'h01});

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 3) d_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 99) < 5) d_sel  = 2'($urandom_range(0, 3));
            d_dis   = ($urandom_range(0, 99) < 8);
            d_stb   = ($urandom_range(0, 99) < 75);
            if ($urandom_range(0, 99) < 15) d_up = ~d_up;
            d_idx   = ($urandom_range(0, 99) < 8);
            d_load  = ($urandom_range(0, 99) < 3);
            d_clear = ($urandom_range(0, 99) < 3);
            d_latch = ($urandom_range(0, 99) < 4);
            d_prwr  = ($urandom_range(0, 99) < 4);
            d_prdata = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(240, 255))
                                                   : 8'($urandom_range(0, 12));
            tick();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule